// File: doc/BRIEF.md
# Two-Channel Byte-Loaded Code Register Pair

This block holds the digital codes for two 12-bit converter channels that are fed from an 8-bit bus. Each channel code is written in two pieces: an eight-bit low part and a four-bit high part. Each piece goes into a first-rank holding register chosen by a two-bit address. A separate update control then copies both holding registers into both committed output registers in the same cycle, so the two channels change together.

All strobes are active low and are sampled on the rising edge of a system clock. A strobe that is held active captures on every clock edge for as long as it is held. Driving update, chip select and write low together makes the path transparent: the byte being written reaches the committed code in the same cycle. An active-low clear resets every register to zero at once, without waiting for a clock edge. The committed codes and the holding-register contents are both brought out.

Top module: `dual_chan_loader`

## Requirements
- R1: While `clr_n` is low, every holding and committed register reads zero. This takes effect without a clock edge.
- R2: A write is `sel_n`=0 and `wr_n`=0, sampled at a rising edge. A write with `addr`=2'b00 stores `din[7:0]` into bits 7..0 of channel A's holding register (`held_a`).
- R3: A write with `addr`=2'b01 stores `din[3:0]` into bits 11..8 of `held_a`. `din[7:4]` is ignored.
- R4: Address 2'b10 targets bits 7..0 of `held_b` from `din[7:0]`. Address 2'b11 targets bits 11..8 of `held_b` from `din[3:0]`.
- R5: While `upd_n` is high, a write changes only the holding registers. `code_a` and `code_b` keep their values, including after a write of only the low byte.
- R6: With `upd_n`=0, `wr_n`=0 and `sel_n`=1 at an edge, both committed codes take their holding-register values at that same edge.
- R7: With `upd_n`, `sel_n` and `wr_n` all low, the written piece shows in both the holding register and the committed code one edge later. No separate update is needed.
- R8: While `wr_n` is high, no register changes, whatever `sel_n`, `upd_n`, `addr` and `din` are.
- R9: With `sel_n` and `upd_n` both high, a low `wr_n` changes no register.
- R10: A write or update that is held active captures on every rising edge it spans. The value from the last edge remains.
- R11: Each committed and held code is formed as {high part, low part}: bits 11..8 are the high part and bits 7..0 are the low part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| upd_n | input | 1 | Update strobe, active low |
| addr | input | 2 | Bit 1 picks the channel (0=A, 1=B); bit 0 picks the part (0=low, 1=high) |
| din | input | 8 | Data bus |
| code_a | output | 12 | Committed code, channel A |
| code_b | output | 12 | Committed code, channel B |
| held_a | output | 12 | Holding-register contents, channel A |
| held_b | output | 12 | Holding-register contents, channel B |

## Verification
Every strobe-driven result, whether a holding-register write, a commit or a transparent write, shows on the outputs after exactly one rising edge. The bench drives each cycle's strobes at the falling edge. It queues the expected four outputs for that cycle, and a monitor compares them 2 ns after the following rising edge. The clear has no clock latency, so it is checked 1 ns after `clr_n` falls, between edges. The checks for held strobes compare after every edge of the hold.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
    localparam int LO_W   = 8;
    localparam int HI_W   = 4;
    localparam int CODE_W = LO_W + HI_W;
    localparam int N_CH   = 2;
    localparam int PARTS  = 2;
    localparam int N_REG  = N_CH * PARTS;
    localparam int ADDR_W = $clog2(N_REG);

    typedef enum logic {
        PART_LO = 1'b0,
        PART_HI = 1'b1
    } part_e;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } chan_word_t;

    function automatic int reg_index(input int ch, input part_e part);
        return ch * PARTS + int'(part);
    endfunction
endpackage

// File: rtl/dcl_addr_dec.sv
module dcl_addr_dec #(
    parameter int N_REG  = dcl_pkg::N_REG,
    parameter int ADDR_W = dcl_pkg::ADDR_W
) (
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_REG-1:0]  we_vec
);
    for (genvar i = 0; i < N_REG; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(i);
        assign we_vec[i] = wr_fire && (addr == MATCH);
    end
endmodule

// File: rtl/dcl_in_chan.sv
module dcl_in_chan #(
    parameter int LO_W   = dcl_pkg::LO_W,
    parameter int HI_W   = dcl_pkg::HI_W,
    localparam int CODE_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [LO_W-1:0]   din,
    output logic [CODE_W-1:0] word_nxt,
    output logic [CODE_W-1:0] word_q
);
    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_we) begin
            st_d.lo = din;
        end
        if (hi_we) begin
            st_d.hi = din[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_nxt = {st_d.hi, st_d.lo};
    assign word_q   = {st_q.hi, st_q.lo};
endmodule

// File: rtl/dcl_commit.sv
module dcl_commit #(
    parameter int CODE_W = dcl_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              commit,
    input  logic [CODE_W-1:0] word_in,
    output logic [CODE_W-1:0] code_q
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.code = word_in;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_q = st_q.code;
endmodule

// File: rtl/dual_chan_loader.sv
module dual_chan_loader
    import dcl_pkg::*;
(
    input  logic              clk,
    input  logic              clr_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              upd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LO_W-1:0]   din,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic [CODE_W-1:0] held_a,
    output logic [CODE_W-1:0] held_b
);
    logic              wr_fire;
    logic              commit;
    logic [N_REG-1:0]  we_vec;
    logic [CODE_W-1:0] nxt_w  [N_CH];
    logic [CODE_W-1:0] held_w [N_CH];
    logic [CODE_W-1:0] code_w [N_CH];

    assign wr_fire = !sel_n && !wr_n;
    assign commit  = !upd_n && !wr_n;

    dcl_addr_dec #(.N_REG(N_REG), .ADDR_W(ADDR_W)) u_dec (
        .wr_fire (wr_fire),
        .addr    (addr),
        .we_vec  (we_vec)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        localparam int LO_IDX = reg_index(ch, PART_LO);
        localparam int HI_IDX = reg_index(ch, PART_HI);

        dcl_in_chan #(.LO_W(LO_W), .HI_W(HI_W)) u_in (
            .clk      (clk),
            .clr_n    (clr_n),
            .lo_we    (we_vec[LO_IDX]),
            .hi_we    (we_vec[HI_IDX]),
            .din      (din),
            .word_nxt (nxt_w[ch]),
            .word_q   (held_w[ch])
        );

        dcl_commit #(.CODE_W(CODE_W)) u_out (
            .clk     (clk),
            .clr_n   (clr_n),
            .commit  (commit),
            .word_in (nxt_w[ch]),
            .code_q  (code_w[ch])
        );
    end

    assign code_a = code_w[0];
    assign code_b = code_w[1];
    assign held_a = held_w[0];
    assign held_b = held_w[1];
endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
    parameter int ADDR_W = dcl_pkg::ADDR_W,
    parameter int LO_W   = dcl_pkg::LO_W,
    parameter int HI_W   = dcl_pkg::HI_W,
    parameter int CODE_W = dcl_pkg::CODE_W
) (
    input logic              clk,
    input logic              clr_n,
    input logic              sel_n,
    input logic              wr_n,
    input logic              upd_n,
    input logic [ADDR_W-1:0] addr,
    input logic [LO_W-1:0]   din,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b,
    input logic [CODE_W-1:0] held_a,
    input logic [CODE_W-1:0] held_b
);
    always @(posedge clk) begin
        if (!clr_n) begin
            AST_CLEAR_ZERO: assert (code_a == '0 && code_b == '0 && held_a == '0 && held_b == '0); // R1
        end
    end

    AST_IDLE_NO_WR: assert property (@(posedge clk) disable iff (!clr_n)
        wr_n |=> ($stable(code_a) && $stable(code_b) && $stable(held_a) && $stable(held_b))); // R8

    AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        (sel_n && upd_n) |=> ($stable(held_a) && $stable(held_b) && $stable(code_a) && $stable(code_b))); // R9

    AST_CODE_NO_UPD: assert property (@(posedge clk) disable iff (!clr_n)
        upd_n |=> ($stable(code_a) && $stable(code_b))); // R5

    AST_UPD_COMMIT: assert property (@(posedge clk) disable iff (!clr_n)
        (!upd_n && !wr_n && sel_n) |=> (code_a == $past(held_a) && code_b == $past(held_b))); // R6

    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!clr_n)
        (!upd_n && !wr_n) |=> (code_a == held_a && code_b == held_b)); // R7

    AST_HI_NIBBLE_A: assert property (@(posedge clk) disable iff (!clr_n)
        (!sel_n && !wr_n && addr == 2'b01) |=> (held_a[CODE_W-1:LO_W] == $past(din[HI_W-1:0]))); // R3
endmodule

bind dual_chan_loader dcl_checker u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .sel_n  (sel_n),
    .wr_n   (wr_n),
    .upd_n  (upd_n),
    .addr   (addr),
    .din    (din),
    .code_a (code_a),
    .code_b (code_b),
    .held_a (held_a),
    .held_b (held_b)
);

// File: tb/dual_chan_loader_tb.sv
module dual_chan_loader_tb;
    logic        clk = 1'b0;
    logic        clr_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        upd_n = 1'b1;
    logic [1:0]  addr = 2'b00;
    logic [7:0]  din = 8'h00;
    logic [11:0] code_a, code_b, held_a, held_b;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [47:0] exp_q[$];
    string       tag_q[$];

    logic [7:0] m_lo [2];
    logic [3:0] m_hi [2];
    logic [11:0] m_out [2];

    always #4 clk = ~clk;

    dual_chan_loader u_dut (
        .clk(clk), .clr_n(clr_n), .sel_n(sel_n), .wr_n(wr_n), .upd_n(upd_n),
        .addr(addr), .din(din), .code_a(code_a), .code_b(code_b),
        .held_a(held_a), .held_b(held_b)
    );

    function automatic logic [47:0] model_vec();
        return {m_out[0], m_out[1], m_hi[0], m_lo[0], m_hi[1], m_lo[1]};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 2; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_out[i] = '0;
        end
    endtask

    task automatic step(input logic s, input logic w, input logic u,
                        input logic [1:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        sel_n = s; wr_n = w; upd_n = u; addr = a; din = d;
        if (!s && !w) begin
            if (a[0]) m_hi[a[1]] = d[3:0];
            else      m_lo[a[1]] = d;
        end
        if (!u && !w) begin
            for (int i = 0; i < 2; i++) m_out[i] = {m_hi[i], m_lo[i]};
        end
        exp_q.push_back(model_vec());
        tag_q.push_back(tag);
    endtask

    task automatic check_now(input string tag);
        logic [47:0] act;
        logic [47:0] exp;
        act = {code_a, code_b, held_a, held_b};
        exp = model_vec();
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [47:0] exp;
            logic [47:0] act;
            string tag;
            exp = exp_q.pop_front();
            tag = tag_q.pop_front();
            act = {code_a, code_b, held_a, held_b};
            checks++;
            if (act !== exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", tag, act, exp);
            end
        end
    end

    task automatic drain();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        model_clear();
        #3;
        check_now("R1 reset state");
        @(negedge clk);
        clr_n = 1'b1;

        step(0, 0, 1, 2'b00, 8'hA5, "R2 A low write");
        step(0, 0, 1, 2'b01, 8'hF3, "R3 A high write, din[7:4] ignored");
        step(0, 0, 1, 2'b10, 8'h5C, "R4 B low write");
        step(0, 0, 1, 2'b11, 8'h0E, "R4 B high write, R5 codes held");
        step(1, 0, 0, 2'b00, 8'h00, "R6 R11 simultaneous update");
        step(0, 1, 0, 2'b00, 8'h11, "R8 write high, nothing changes");
        step(1, 1, 1, 2'b11, 8'hFF, "R8 idle");
        step(1, 0, 1, 2'b10, 8'h22, "R9 deselected, no update");
        step(0, 0, 1, 2'b00, 8'h77, "R5 low byte only, code unchanged");
        step(1, 1, 1, 2'b00, 8'h00, "R5 still unchanged");
        step(1, 0, 0, 2'b00, 8'h00, "R6 update after low byte");
        step(0, 0, 0, 2'b10, 8'h99, "R7 transparent write B low");
        step(0, 0, 0, 2'b01, 8'h0C, "R7 transparent write A high");
        step(0, 0, 1, 2'b11, 8'h01, "R10 held write edge 1");
        step(0, 0, 1, 2'b11, 8'h02, "R10 held write edge 2");
        step(0, 0, 1, 2'b11, 8'h0F, "R10 held write edge 3");
        step(1, 0, 0, 2'b00, 8'h00, "R10 held update edge 1");
        step(1, 0, 0, 2'b00, 8'h00, "R10 held update edge 2");
        step(1, 1, 1, 2'b00, 8'h00, "R11 idle code form");
        drain();

        @(negedge clk);
        #1;
        clr_n = 1'b0;
        model_clear();
        #1;
        check_now("R1 asynchronous clear");
        @(negedge clk);
        check_now("R1 clear held");
        clr_n = 1'b1;

        step(0, 0, 1, 2'b01, 8'hB4, "R3 high after clear");
        step(1, 0, 0, 2'b00, 8'h00, "R6 R11 commit high only");
        step(1, 1, 1, 2'b00, 8'h00, "R8 final idle");
        drain();

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule